// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits on the write path of a byte-wide nonvolatile memory. It sees each write transaction (a 16-bit address and an 8-bit data byte) and looks for two command codes hidden in the write stream. The short code is three writes. It turns protection on if it was off, and it opens a single page-load window, so that one burst of data bytes can reach the array. When that window closes, protection applies again with no further action. The long code is six writes. It turns protection off for good, but only after a programmable settle delay has elapsed.

For every write, the block gives two answers in the same cycle. The first says whether the write may be programmed into the array (`wrPass`). The second says whether the write is a step of a command sequence and must not be stored (`wrCmd`). The persistent protection flag is held as a register. Its reset value is a parameter, and it is reported on `protOn`. A separate page-load timer reports the end of a byte-load burst on `loadEnd`.

Top module: `wp_cmd_seq`

## Requirements
- R1: After reset `protOn` equals the PROT_RESET parameter (default 0). While protection is off, every write that is not a command step is passed (`wrPass`=1).
- R2: The three writes 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555 set `protOn` to 1 on the clock edge of the third write, whatever its earlier value, and open a page-load window.
- R3: Each write that matches the next expected command step, or that is a fresh 0xAA to 0x5555 outside a window, is flagged with `wrCmd`=1 and `wrPass`=0.
- R4: Inside a window, every write passes and no write is treated as a command. The window closes after the edge of its PAGE_BYTES-th write.
- R5: A `loadEnd` pulse closes an open window at that edge if at least one byte has been loaded, counting a write in the same cycle. A pulse in a window that has no bytes yet has no effect.
- R6: While `protOn` is 1 and no window is open, a write that is not a command step is blocked (`wrPass`=0).
- R7: The six writes 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, 0x20 to 0x5555 make `protOn` fall exactly SETTLE_CYCLES clock edges after the edge of the sixth write.
- R8: A write that breaks a partial sequence aborts it. If that write is 0xAA to 0x5555, it counts as step one of a new sequence; otherwise it is handled as a data write.
- R9: Address bit 15 is ignored when matching command addresses (0xD555 matches 0x5555, 0xAAAA matches 0x2AAA).
- R10: `wrPass` and `wrCmd` are never both 1, and both are 0 in a cycle with no write.
- R11: An unlock sequence that completes while a disable is still settling cancels the pending clear, and `protOn` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A write transaction is present this cycle |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| loadEnd | input | 1 | Page-load timer reports that the byte-load burst has ended |
| wrPass | output | 1 | This write may be programmed into the array |
| wrCmd | output | 1 | This write is a command step and must not be stored |
| protOn | output | 1 | Current state of the persistent protection flag |

## Verification
The bound checker watches a set of rules on every cycle: the gate outputs are mutually exclusive and quiet when there is no write, an open window always implies protection, a protected write outside a window is blocked, an unprotected data write passes, the window count never goes past the page size, and an early `loadEnd` closes a loaded window. Other behaviour only shows in the bench's scenarios: the exact code values, the abort-and-restart rule, the bit-15 alias, the exact settle delay, and a clear that is cancelled by a later unlock. For these, the bench compares a behavioural model against the ports on every clock.

// File: rtl/wp_cmd_pkg.sv
package wp_cmd_pkg;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  CODE_LEAD  = 8'hAA;
  localparam logic [7:0]  CODE_SECOND = 8'h55;
  localparam logic [7:0]  CODE_UNLOCK = 8'hA0;
  localparam logic [7:0]  CODE_EXTEND = 8'h80;
  localparam logic [7:0]  CODE_CLEAR  = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_S4   = 3'd4,
    ST_S5   = 3'd5
  } seqStage_t;

  // decoded command keys for the current write
  typedef struct packed {
    logic kLead;    // 0xAA at the A key address
    logic kSecond;  // 0x55 at the B key address
    logic kUnlock;  // 0xA0 at the A key address
    logic kExtend;  // 0x80 at the A key address
    logic kClear;   // 0x20 at the A key address
  } keyHit_t;

  // strobes from control to datapath
  typedef struct packed {
    logic winClr;
    logic winInc;
    logic settleLoad;
    logic settleStop;
  } dpStrobe_t;

endpackage

// File: rtl/wp_cmd_dp.sv
module wp_cmd_dp
  import wp_cmd_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int PAGE_BYTES    = 128,
  parameter int SETTLE_CYCLES = 16,
  localparam int CNT_W = $clog2(PAGE_BYTES + 1),
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  dpStrobe_t         strobe,
  output keyHit_t           keyHit,
  output logic [CNT_W-1:0]  winCnt,
  output logic              winLast,
  output logic              winAny,
  output logic              settleFire
);

  localparam int CMP_W = ADDR_W - 1;   // top address bit is not compared

  logic [CMP_W-1:0] addrLow;
  logic             isAddrA;
  logic             isAddrB;
  logic [SET_W-1:0] settleCnt;

  assign addrLow = wrAddr[CMP_W-1:0];
  assign isAddrA = (addrLow == CMP_W'(KEY_ADDR_A));
  assign isAddrB = (addrLow == CMP_W'(KEY_ADDR_B));

  always_comb begin
    keyHit.kLead   = isAddrA && (wrData == DATA_W'(CODE_LEAD));
    keyHit.kSecond = isAddrB && (wrData == DATA_W'(CODE_SECOND));
    keyHit.kUnlock = isAddrA && (wrData == DATA_W'(CODE_UNLOCK));
    keyHit.kExtend = isAddrA && (wrData == DATA_W'(CODE_EXTEND));
    keyHit.kClear  = isAddrA && (wrData == DATA_W'(CODE_CLEAR));
  end

  // page-window byte counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (strobe.winClr) begin
      winCnt <= '0;
    end else if (strobe.winInc) begin
      winCnt <= winCnt + CNT_W'(1);
    end
  end

  assign winLast = (winCnt == CNT_W'(PAGE_BYTES - 1));
  assign winAny  = (winCnt != '0);

  // settle counter for the disable command
  always_ff @(posedge clk) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strobe.settleLoad) begin
      settleCnt <= SET_W'(SETTLE_CYCLES);
    end else if (strobe.settleStop) begin
      settleCnt <= '0;
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - SET_W'(1);
    end
  end

  assign settleFire = (settleCnt == SET_W'(1));

endmodule

// File: rtl/wp_cmd_ctl.sv
module wp_cmd_ctl
  import wp_cmd_pkg::*;
#(
  parameter bit PROT_RESET = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrValid,
  input  logic      loadEnd,
  input  keyHit_t   keyHit,
  input  logic      winLast,
  input  logic      winAny,
  input  logic      settleFire,
  output dpStrobe_t strobe,
  output logic      wrPass,
  output logic      wrCmd,
  output logic      protOn,
  output logic      winOpen
);

  seqStage_t stage, stageNext;
  logic      protFlag, protNext;
  logic      winNext;
  logic      advance;

  always_comb begin
    stageNext = stage;
    protNext  = protFlag;
    winNext   = winOpen;
    strobe    = '0;
    wrPass    = 1'b0;
    wrCmd     = 1'b0;
    advance   = 1'b0;

    if (wrValid) begin
      if (winOpen) begin
        wrPass        = 1'b1;
        strobe.winInc = 1'b1;
        if (winLast) winNext = 1'b0;
      end else begin
        unique case (stage)
          ST_IDLE: if (keyHit.kLead) begin
            advance = 1'b1; stageNext = ST_S1;
          end
          ST_S1: if (keyHit.kSecond) begin
            advance = 1'b1; stageNext = ST_S2;
          end
          ST_S2: begin
            if (keyHit.kUnlock) begin
              advance           = 1'b1;
              stageNext         = ST_IDLE;
              protNext          = 1'b1;
              winNext           = 1'b1;
              strobe.winClr     = 1'b1;
              strobe.settleStop = 1'b1;
            end else if (keyHit.kExtend) begin
              advance = 1'b1; stageNext = ST_S3;
            end
          end
          ST_S3: if (keyHit.kLead) begin
            advance = 1'b1; stageNext = ST_S4;
          end
          ST_S4: if (keyHit.kSecond) begin
            advance = 1'b1; stageNext = ST_S5;
          end
          ST_S5: if (keyHit.kClear) begin
            advance           = 1'b1;
            stageNext         = ST_IDLE;
            strobe.settleLoad = 1'b1;
          end
          default: stageNext = ST_IDLE;
        endcase

        if (advance) begin
          wrCmd = 1'b1;
        end else if (keyHit.kLead) begin
          // abort, but this write may open a new sequence
          wrCmd     = 1'b1;
          stageNext = ST_S1;
        end else begin
          stageNext = ST_IDLE;
          wrPass    = !protFlag;
        end
      end
    end

    if (loadEnd && winOpen && (winAny || wrValid)) winNext = 1'b0;

    if (settleFire && !strobe.settleLoad && !strobe.settleStop) protNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage    <= ST_IDLE;
      protFlag <= PROT_RESET;
      winOpen  <= 1'b0;
    end else begin
      stage    <= stageNext;
      protFlag <= protNext;
      winOpen  <= winNext;
    end
  end

  assign protOn = protFlag;

endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
  import wp_cmd_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int PAGE_BYTES    = 128,
  parameter int SETTLE_CYCLES = 16,
  parameter bit PROT_RESET    = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadEnd,
  output logic              wrPass,
  output logic              wrCmd,
  output logic              protOn
);

  localparam int CNT_W = $clog2(PAGE_BYTES + 1);

  dpStrobe_t        strobe;
  keyHit_t          keyHit;
  logic [CNT_W-1:0] winCnt;
  logic             winLast;
  logic             winAny;
  logic             settleFire;
  logic             winOpen;

  wp_cmd_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PAGE_BYTES(PAGE_BYTES), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .keyHit(keyHit), .winCnt(winCnt),
    .winLast(winLast), .winAny(winAny), .settleFire(settleFire)
  );

  wp_cmd_ctl #(.PROT_RESET(PROT_RESET)) u_ctl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .loadEnd(loadEnd),
    .keyHit(keyHit), .winLast(winLast), .winAny(winAny),
    .settleFire(settleFire), .strobe(strobe), .wrPass(wrPass),
    .wrCmd(wrCmd), .protOn(protOn), .winOpen(winOpen)
  );

endmodule

// File: rtl/wp_cmd_seq_chk.sv
module wp_cmd_seq_chk #(
  parameter int PAGE_BYTES = 128,
  localparam int CNT_W = $clog2(PAGE_BYTES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrValid,
  input logic             loadEnd,
  input logic             wrPass,
  input logic             wrCmd,
  input logic             protOn,
  input logic             winOpen,
  input logic [CNT_W-1:0] winCnt
);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(wrPass && wrCmd));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> (!wrPass && !wrCmd));

  p_unprot_pass_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !protOn && !wrCmd) |-> wrPass);

  p_window_prot_r2: assert property (@(posedge clk) disable iff (!rstN)
    winOpen |-> protOn);

  p_window_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (winOpen && wrValid) |-> (wrPass && !wrCmd));

  p_window_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= CNT_W'(PAGE_BYTES));

  p_early_close_r5: assert property (@(posedge clk) disable iff (!rstN)
    (loadEnd && winOpen && winCnt != '0) |=> !winOpen);

  p_blocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && protOn && !winOpen && !wrCmd) |-> !wrPass);

  p_clear_closed_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protOn) |-> !winOpen);

endmodule

bind wp_cmd_seq wp_cmd_seq_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .loadEnd(loadEnd),
  .wrPass(wrPass), .wrCmd(wrCmd), .protOn(protOn),
  .winOpen(winOpen), .winCnt(winCnt)
);

// File: tb/wp_cmd_seq_tb.sv
`timescale 1ns/1ps
module wp_cmd_seq_tb;

  localparam int PAGE   = 16;
  localparam int SETTLE = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        loadEnd = 1'b0;
  logic        wrPass, wrCmd, protOn;

  int nCompared = 0;
  int nMismatch = 0;
  bit finished = 1'b0;

  // behavioural model state
  int mStage = 0;
  bit mWin = 0;
  bit mProt = 0;
  int mCnt = 0;
  int mSettle = 0;

  always #10 clk = ~clk;

  wp_cmd_seq #(.PAGE_BYTES(PAGE), .SETTLE_CYCLES(SETTLE), .PROT_RESET(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .loadEnd(loadEnd), .wrPass(wrPass), .wrCmd(wrCmd), .protOn(protOn)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock with the given stimulus; compares outputs, then advances the model
  task automatic cyc(bit v, logic [15:0] a, logic [7:0] d, bit le, string tag);
    bit ePass, eCmd, unlockNow, clearNow, adv, nWin, nProt;
    int nStage, nCnt, nSettle;
    logic [15:0] lo;
    bit kLead, kSec, kUnl, kExt, kClr;
    @(negedge clk);
    wrValid = v; wrAddr = a; wrData = d; loadEnd = le;
    #5;
    lo = a & 16'h7FFF;
    kLead = (lo == 16'h5555) && (d == 8'hAA);
    kSec  = (lo == 16'h2AAA) && (d == 8'h55);
    kUnl  = (lo == 16'h5555) && (d == 8'hA0);
    kExt  = (lo == 16'h5555) && (d == 8'h80);
    kClr  = (lo == 16'h5555) && (d == 8'h20);
    ePass = 0; eCmd = 0; unlockNow = 0; clearNow = 0; adv = 0;
    nStage = mStage; nWin = mWin; nProt = mProt; nCnt = mCnt; nSettle = mSettle;
    if (v) begin
      if (mWin) begin
        ePass = 1; nCnt = mCnt + 1;
        if (nCnt == PAGE) nWin = 0;
      end else begin
        if      (mStage == 0 && kLead) begin adv = 1; nStage = 1; end
        else if (mStage == 1 && kSec)  begin adv = 1; nStage = 2; end
        else if (mStage == 2 && kUnl)  begin adv = 1; nStage = 0; unlockNow = 1; end
        else if (mStage == 2 && kExt)  begin adv = 1; nStage = 3; end
        else if (mStage == 3 && kLead) begin adv = 1; nStage = 4; end
        else if (mStage == 4 && kSec)  begin adv = 1; nStage = 5; end
        else if (mStage == 5 && kClr)  begin adv = 1; nStage = 0; clearNow = 1; end
        if (adv) eCmd = 1;
        else if (kLead) begin eCmd = 1; nStage = 1; end
        else begin nStage = 0; ePass = !mProt; end
      end
    end
    if (le && mWin && (mCnt > 0 || v)) nWin = 0;
    if (unlockNow) begin nProt = 1; nWin = 1; nCnt = 0; end
    if (clearNow) nSettle = SETTLE;
    else if (unlockNow) nSettle = 0;
    else if (mSettle > 0) begin
      nSettle = mSettle - 1;
      if (nSettle == 0) nProt = 0;
    end
    check(tag, "wrPass", wrPass, ePass);
    check(tag, "wrCmd", wrCmd, eCmd);
    check(tag, "protOn", protOn, mProt);
    @(posedge clk);
    mStage = nStage; mWin = nWin; mProt = nProt; mCnt = nCnt; mSettle = nSettle;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, string tag);
    cyc(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 8'h0, 1'b0, tag);
  endtask

  task automatic unlockSeq(string tag);
    wr(16'h5555, 8'hAA, tag); wr(16'h2AAA, 8'h55, tag); wr(16'h5555, 8'hA0, tag);
  endtask

  task automatic clearSeq(string tag);
    wr(16'h5555, 8'hAA, tag); wr(16'h2AAA, 8'h55, tag); wr(16'h5555, 8'h80, tag);
    wr(16'h5555, 8'hAA, tag); wr(16'h2AAA, 8'h55, tag); wr(16'h5555, 8'h20, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nMismatch++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1", "protOn in reset", protOn, 1'b0);
    @(negedge clk); rstN = 1'b1;

    // R1: unprotected data writes pass
    wr(16'h1234, 8'h5A, "R1"); wr(16'h0000, 8'hFF, "R1"); idle(2, "R10");

    // R2/R3: unlock sets protection, R4 window passes bytes, R5 loadEnd closes it
    unlockSeq("R2");
    wr(16'h0100, 8'h11, "R4"); wr(16'h0101, 8'h22, "R4");
    wr(16'h5555, 8'hAA, "R4"); // inside window this is data
    cyc(1'b0, 16'h0, 8'h0, 1'b1, "R5");
    wr(16'h0102, 8'h33, "R6"); idle(1, "R6");

    // R5: loadEnd with empty window is ignored, then a byte with loadEnd closes it
    unlockSeq("R5");
    cyc(1'b0, 16'h0, 8'h0, 1'b1, "R5");
    wr(16'h0200, 8'h44, "R5");
    cyc(1'b1, 16'h0201, 8'h55, 1'b1, "R5");
    wr(16'h0202, 8'h66, "R6");

    // R4: full page closes window by count
    unlockSeq("R4");
    for (int i = 0; i < PAGE + 2; i++) wr(16'h0300 + 16'(i), 8'(i), "R4");

    // R8: aborts and restart on a fresh lead write
    wr(16'h5555, 8'hAA, "R8"); wr(16'h1111, 8'h01, "R8");
    wr(16'h5555, 8'hAA, "R8"); wr(16'h2AAA, 8'h55, "R8"); wr(16'h5555, 8'h12, "R8");
    wr(16'h5555, 8'hAA, "R8"); wr(16'h5555, 8'hAA, "R8");
    wr(16'h2AAA, 8'h55, "R8"); wr(16'h5555, 8'hA0, "R8");
    wr(16'h0400, 8'h77, "R8"); cyc(1'b0, 16'h0, 8'h0, 1'b1, "R8");

    // R7: disable with settle delay
    clearSeq("R7");
    idle(SETTLE + 2, "R7");
    wr(16'h0500, 8'h88, "R1");

    // R9: bit 15 aliases, R2 unlock from unprotected
    wr(16'hD555, 8'hAA, "R9"); wr(16'hAAAA, 8'h55, "R9"); wr(16'hD555, 8'hA0, "R9");
    wr(16'h8600, 8'h99, "R9"); cyc(1'b0, 16'h0, 8'h0, 1'b1, "R9");
    wr(16'h0601, 8'h9A, "R6");

    // R11: unlock during settle cancels clear
    clearSeq("R11");
    idle(1, "R11");
    unlockSeq("R11");
    wr(16'h0700, 8'hAB, "R11"); cyc(1'b0, 16'h0, 8'h0, 1'b1, "R11");
    idle(SETTLE + 2, "R11");
    wr(16'h0701, 8'hAC, "R11");

    // R7: full clear with interleaved idle, then R3 command writes are still flagged
    clearSeq("R7"); idle(SETTLE + 1, "R7");
    wr(16'h5555, 8'hAA, "R3"); wr(16'h3333, 8'h00, "R3");
    idle(2, "R10");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule